// File: doc/BRIEF.md
# Link Health Monitor with Stuck-Lock Receive Reset

This block decides, on request, whether a serial link is really usable, and clears one known hang that can occur while the link moves to a faster rate. A pulse on `start_i` launches one check. The check reads two live debug status words from the link controller. One of them carries a link-up bit and a still-training bit. If the link is up and trained, the check reports success straight away. If the link is up but still training, the block waits a programmable interval and looks again. It does this a bounded number of times.

If the link is down, or training never settles, the block reads a PHY status register through an indirect request/response port. The hang it looks for is a receiver with no valid data while the training state machine sits in the receiver-lock recovery state. When both are true, the block sets and then clears two receive-override bits in a PHY override register. Each change is a read-modify-write, and the block holds the bits set for a programmable interval between the two. A saturating event counter and a sticky flag record completed recoveries. An error returned on the PHY port ends the check and raises a sticky fault flag.

Top module: `lnk_health_mon`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `link_up_o`, `fault_o`, `stuck_seen_o` and `phy_req_o` are 0 and `stuck_cnt_o` is 0.
- R2: A `start_i` pulse while idle starts a check, which is sampled at the next edge. A `start_i` pulse while busy is ignored: it neither restarts the check nor causes a second `done_o`. `phy_req_o` stays low while idle.
- R3: Bit 4 of `dbg1_i` means link up and bit 29 means in training. On the first sample edge after start, up=1 and training=0 gives `done_o` one edge later (latency 1 edge), with `link_up_o`=1 and no PHY access. `done_o` is a single-cycle pulse, and `link_up_o` holds the result until the next `done_o`.
- R4: While up=1 and training=1, the block samples again after WAIT_CYC idle cycles, at most RETRY_MAX more times. A sample with up=1 and training=0 ends the check with `link_up_o`=1, and the latency is 1+j*(WAIT_CYC+1) for success at re-sample j. A sample with up=0, or a sample with training still set after the last retry, goes to the stuck check, and that check ends with `link_up_o`=0.
- R5: The stuck check first reads address STAT_ADDR (0x100D). If bit 0 of the read data (receive valid) is 1, the check ends with no further access, whatever the other bits are.
- R6: If receive valid is 0 and `dbg0_i[5:0]` is not 0x0D (receiver-lock recovery), the check ends with no write. Bits of `dbg0_i` above bit 5 are ignored.
- R7: If receive valid is 0 and `dbg0_i[5:0]`=0x0D, the block performs five accesses in order: read OVR_ADDR (0x1005), write the read value OR 0x0028, idle for exactly HOLD_CYC cycles, read OVR_ADDR again, then write the second value AND NOT 0x0028. No write goes to any other address.
- R8: Each completed recovery raises sticky `stuck_seen_o` and adds 1 to `stuck_cnt_o`, which saturates at all-ones when CNT_SAT=1. Checks that perform no recovery change neither.
- R9: `phy_err_i` together with `phy_done_i` ends the check at once. `done_o` then pulses with `link_up_o`=0, `fault_o` becomes set and stays set, no further access is made, and the counter is unchanged.
- R10: `phy_req_o` stays high with `phy_addr_o`, `phy_we_o` and `phy_wdata_o` stable until a cycle with `phy_done_i` high. A request still high on the following cycle begins the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to launch one health check |
| dbg0_i | input | DBG_W | Debug word holding the training state code in bits [5:0] |
| dbg1_i | input | DBG_W | Debug word holding the link-up and in-training bits |
| phy_req_o | output | 1 | Indirect PHY access request |
| phy_we_o | output | 1 | 1 = write access, 0 = read access |
| phy_addr_o | output | PA_W | PHY register address |
| phy_wdata_o | output | PD_W | PHY write data |
| phy_done_i | input | 1 | Access complete (one cycle) |
| phy_rdata_i | input | PD_W | Read data, valid with `phy_done_i` |
| phy_err_i | input | 1 | Access failed, valid with `phy_done_i` |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse when a check ends |
| link_up_o | output | 1 | Result of the last check |
| fault_o | output | 1 | Sticky: a PHY access returned an error |
| stuck_seen_o | output | 1 | Sticky: at least one recovery has completed |
| stuck_cnt_o | output | CNT_W | Number of completed recoveries (saturating) |

## Verification
Two functions can meet in the same cycle. A new `start_i` request can arrive while a retry wait or a recovery is running. An error completion on the PHY port can also coincide with any step of the read-modify-write sequence. The bench provokes the first by pulsing start in the middle of a training wait, and judges it by an unchanged completion latency and the absence of a second `done_o`. It provokes the second by injecting an error at each of the five recovery accesses in turn, and judges it by the number of accesses logged, the fault flag and the unchanged event counter.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SAMPLE,
      S_TWAIT,
      S_RD_STAT,
      S_RD_OVR1,
      S_WR_SET,
      S_HOLD,
      S_RD_OVR2,
      S_WR_CLR
   } lhm_state_t;

   function automatic logic lhm_is_access(input lhm_state_t s);
      return (s == S_RD_STAT) || (s == S_RD_OVR1) || (s == S_WR_SET) ||
             (s == S_RD_OVR2) || (s == S_WR_CLR);
   endfunction

endpackage

// File: rtl/lhm_timer.sv
module lhm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lhm_evt_ctr.sv
module lhm_evt_ctr #(
   parameter int W   = 8,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   if (SAT) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt_q <= '0;
         else if (inc_i && (cnt_q != '1))    cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q <= '0;
         else if (inc_i)   cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/lnk_health_mon.sv
module lnk_health_mon
   import lhm_pkg::*;
#(
   parameter int               DBG_W     = 32,
   parameter int               PA_W      = 16,
   parameter int               PD_W      = 16,
   parameter int               UP_BIT    = 4,
   parameter int               TRN_BIT   = 29,
   parameter int               RETRY_MAX = 5,
   parameter int               WAIT_CYC  = 200000,
   parameter int               HOLD_CYC  = 400000,
   parameter int               VALID_BIT = 0,
   parameter int               LOCK_W    = 6,
   parameter logic [LOCK_W-1:0] LOCK_CODE = 6'h0D,
   parameter logic [PA_W-1:0]  STAT_ADDR = 16'h100D,
   parameter logic [PA_W-1:0]  OVR_ADDR  = 16'h1005,
   parameter logic [PD_W-1:0]  OVR_MASK  = 16'h0028,
   parameter int               CNT_W     = 8,
   parameter bit               CNT_SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DBG_W-1:0] dbg0_i,
   input  logic [DBG_W-1:0] dbg1_i,
   output logic             phy_req_o,
   output logic             phy_we_o,
   output logic [PA_W-1:0]  phy_addr_o,
   output logic [PD_W-1:0]  phy_wdata_o,
   input  logic             phy_done_i,
   input  logic [PD_W-1:0]  phy_rdata_i,
   input  logic             phy_err_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             link_up_o,
   output logic             fault_o,
   output logic             stuck_seen_o,
   output logic [CNT_W-1:0] stuck_cnt_o
);
   localparam int RTY_W   = (RETRY_MAX < 1) ? 1 : $clog2(RETRY_MAX + 1);
   localparam int TMR_MAX = (WAIT_CYC > HOLD_CYC) ? WAIT_CYC : HOLD_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] WAIT_LD = TMR_W'(WAIT_CYC - 1);
   localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(HOLD_CYC - 1);

   // elaboration-time parameter checks
   if (UP_BIT >= DBG_W || TRN_BIT >= DBG_W || UP_BIT == TRN_BIT) begin : g_bad_bits
      $error("lnk_health_mon: status bit positions out of range or equal");
   end
   if (LOCK_W < 1 || LOCK_W > DBG_W) begin : g_bad_lock
      $error("lnk_health_mon: LOCK_W out of range");
   end
   if (VALID_BIT >= PD_W) begin : g_bad_valid
      $error("lnk_health_mon: VALID_BIT out of range");
   end
   if (WAIT_CYC < 1 || HOLD_CYC < 1 || RETRY_MAX < 0 || CNT_W < 1) begin : g_bad_timing
      $error("lnk_health_mon: wait, hold, retry or counter parameter invalid");
   end

   lhm_state_t       st_q, st_n;
   logic [RTY_W-1:0] rty_q;
   logic [PD_W-1:0]  ovr_q;
   logic             done_q, up_q, fault_q, seen_q;

   logic             fin, fin_up, flt, cap, inc, rty_ld, rty_dec, t_ld, t_zero;
   logic [TMR_W-1:0] t_val;
   logic             smp_up, smp_trn, rx_valid, at_lock;

   logic unused_input_bits;
   assign unused_input_bits = ^{dbg0_i, dbg1_i};

   assign smp_up   = dbg1_i[UP_BIT];
   assign smp_trn  = dbg1_i[TRN_BIT];
   assign rx_valid = phy_rdata_i[VALID_BIT];
   assign at_lock  = (dbg0_i[LOCK_W-1:0] == LOCK_CODE);

   always_comb begin
      st_n    = st_q;
      fin     = 1'b0;
      fin_up  = 1'b0;
      flt     = 1'b0;
      cap     = 1'b0;
      inc     = 1'b0;
      rty_ld  = 1'b0;
      rty_dec = 1'b0;
      t_ld    = 1'b0;
      t_val   = WAIT_LD;
      case (st_q)
         S_IDLE: begin
            if (start_i) begin
               st_n   = S_SAMPLE;
               rty_ld = 1'b1;
            end
         end
         S_SAMPLE: begin
            if (!smp_up)              st_n = S_RD_STAT;
            else if (!smp_trn) begin
               fin    = 1'b1;
               fin_up = 1'b1;
            end else if (rty_q == '0) st_n = S_RD_STAT;
            else begin
               rty_dec = 1'b1;
               t_ld    = 1'b1;
               st_n    = S_TWAIT;
            end
         end
         S_TWAIT: if (t_zero) st_n = S_SAMPLE;
         S_HOLD:  if (t_zero) st_n = S_RD_OVR2;
         default: begin
            if (!lhm_is_access(st_q)) st_n = S_IDLE;
            else if (phy_done_i) begin
               if (phy_err_i) begin
                  flt = 1'b1;
                  fin = 1'b1;
               end else begin
                  case (st_q)
                     S_RD_STAT: begin
                        if (rx_valid || !at_lock) fin = 1'b1;
                        else                      st_n = S_RD_OVR1;
                     end
                     S_RD_OVR1: begin
                        cap  = 1'b1;
                        st_n = S_WR_SET;
                     end
                     S_WR_SET: begin
                        t_ld  = 1'b1;
                        t_val = HOLD_LD;
                        st_n  = S_HOLD;
                     end
                     S_RD_OVR2: begin
                        cap  = 1'b1;
                        st_n = S_WR_CLR;
                     end
                     default: begin
                        inc = 1'b1;
                        fin = 1'b1;
                     end
                  endcase
               end
            end
         end
      endcase
      if (fin) st_n = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         rty_q   <= '0;
         ovr_q   <= '0;
         done_q  <= 1'b0;
         up_q    <= 1'b0;
         fault_q <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         done_q <= fin;
         if (rty_ld)       rty_q <= RTY_W'(RETRY_MAX);
         else if (rty_dec) rty_q <= rty_q - 1'b1;
         if (cap)          ovr_q <= phy_rdata_i;
         if (fin)          up_q  <= fin_up;
         if (flt)          fault_q <= 1'b1;
         if (inc)          seen_q  <= 1'b1;
      end
   end

   lhm_timer #(.W(TMR_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (t_ld),
      .val_i  (t_val),
      .zero_o (t_zero)
   );

   lhm_evt_ctr #(.W(CNT_W), .SAT(CNT_SAT)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (inc),
      .cnt_o (stuck_cnt_o)
   );

   assign phy_req_o    = lhm_is_access(st_q);
   assign phy_we_o     = (st_q == S_WR_SET) || (st_q == S_WR_CLR);
   assign phy_addr_o   = (st_q == S_RD_STAT) ? STAT_ADDR : OVR_ADDR;
   assign phy_wdata_o  = (st_q == S_WR_SET) ? (ovr_q | OVR_MASK) :
                         (st_q == S_WR_CLR) ? (ovr_q & ~OVR_MASK) : '0;
   assign busy_o       = (st_q != S_IDLE);
   assign done_o       = done_q;
   assign link_up_o    = up_q;
   assign fault_o      = fault_q;
   assign stuck_seen_o = seen_q;
endmodule

// File: rtl/lhm_chk.sv
module lhm_chk #(
   parameter int              PA_W     = 16,
   parameter int              PD_W     = 16,
   parameter int              CNT_W    = 8,
   parameter logic [PA_W-1:0] OVR_ADDR = 16'h1005,
   parameter logic [PD_W-1:0] OVR_MASK = 16'h0028
) (
   input logic             clk,
   input logic             rst_n,
   input logic             phy_req_o,
   input logic             phy_we_o,
   input logic [PA_W-1:0]  phy_addr_o,
   input logic [PD_W-1:0]  phy_wdata_o,
   input logic             phy_done_i,
   input logic             phy_err_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             fault_o,
   input logic             stuck_seen_o,
   input logic [CNT_W-1:0] stuck_cnt_o
);
   a_r2_no_access_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !phy_req_o);

   a_r10_req_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_o && !phy_done_i |=> phy_req_o && $stable(phy_addr_o) &&
                                   $stable(phy_we_o) && $stable(phy_wdata_o));

   a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r3_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r7_write_only_override: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_o && phy_we_o |-> phy_addr_o == OVR_ADDR);

   a_r7_mask_bits_paired: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_o && phy_we_o |-> ((phy_wdata_o & OVR_MASK) == '0) ||
                                ((phy_wdata_o & OVR_MASK) == OVR_MASK));

   a_r9_err_stops_access: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_o && phy_done_i && phy_err_i |=> !phy_req_o && fault_o);

   a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);

   a_r8_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_seen_o |=> stuck_seen_o);

   a_r8_count_needs_seen: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_cnt_o != $past(stuck_cnt_o) |-> stuck_seen_o);
endmodule

bind lnk_health_mon lhm_chk #(
   .PA_W(PA_W), .PD_W(PD_W), .CNT_W(CNT_W), .OVR_ADDR(OVR_ADDR), .OVR_MASK(OVR_MASK)
) u_lhm_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .phy_req_o    (phy_req_o),
   .phy_we_o     (phy_we_o),
   .phy_addr_o   (phy_addr_o),
   .phy_wdata_o  (phy_wdata_o),
   .phy_done_i   (phy_done_i),
   .phy_err_i    (phy_err_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .fault_o      (fault_o),
   .stuck_seen_o (stuck_seen_o),
   .stuck_cnt_o  (stuck_cnt_o)
);

// File: tb/lnk_health_mon_tb_top.sv
`timescale 1ns/1ps
module lnk_health_mon_tb_top;
   localparam int W   = 4;
   localparam int H   = 6;
   localparam int RTY = 5;
   localparam logic [31:0] UP   = 32'h0000_0010;
   localparam logic [31:0] TRN  = 32'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dbg0 = '0, dbg1 = '0;
   logic        phy_req, phy_we;
   logic [15:0] phy_addr, phy_wdata;
   logic        phy_done = 1'b0, phy_err = 1'b0;
   logic [15:0] phy_rdata = '0;
   logic        busy, done, link_up, fault, seen;
   logic [1:0]  cnt;

   always #2.5 clk = ~clk;

   lnk_health_mon #(.WAIT_CYC(W), .HOLD_CYC(H), .RETRY_MAX(RTY), .CNT_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dbg0_i(dbg0), .dbg1_i(dbg1),
      .phy_req_o(phy_req), .phy_we_o(phy_we), .phy_addr_o(phy_addr),
      .phy_wdata_o(phy_wdata), .phy_done_i(phy_done), .phy_rdata_i(phy_rdata),
      .phy_err_i(phy_err), .busy_o(busy), .done_o(done), .link_up_o(link_up),
      .fault_o(fault), .stuck_seen_o(seen), .stuck_cnt_o(cnt)
   );

   int n_chk = 0, n_bad = 0;

   // responder configuration (written by the stimulus only)
   int          lat = 1, err_at = -1, run_id = 0;
   logic [15:0] stat_val = '0, v1 = '0, v2 = '0;
   // responder state and log (written by the responder only)
   int          seen_id = 0, tr_n = 0, wcnt = 0, idle = 0, ovr_i = 0, stab_err = 0;
   logic [15:0] a0 = '0, wd0 = '0;
   logic        we0 = 1'b0;
   logic [15:0] lg_addr [8];
   logic [15:0] lg_wd [8];
   logic        lg_we [8];
   int          lg_idle [8];

   always @(negedge clk) begin
      if (!rst_n) begin
         phy_done = 1'b0;
         phy_err  = 1'b0;
         wcnt     = 0;
      end else begin
         if (run_id != seen_id) begin
            seen_id = run_id; tr_n = 0; idle = 0; ovr_i = 0;
         end
         if (phy_done) begin
            phy_done = 1'b0; phy_err = 1'b0; wcnt = 0; idle = 0;
         end
         if (phy_req) begin
            if (wcnt == 0) begin
               a0 = phy_addr; we0 = phy_we; wd0 = phy_wdata;
            end else if (phy_addr != a0 || phy_we != we0 || phy_wdata != wd0) begin
               stab_err++;
            end
            wcnt++;
            if (wcnt >= lat) begin
               phy_done = 1'b1;
               phy_err  = (tr_n == err_at);
               if (phy_we) phy_rdata = 16'hDEAD;
               else if (phy_addr == 16'h100D) phy_rdata = stat_val;
               else begin
                  phy_rdata = (ovr_i == 0) ? v1 : v2;
                  ovr_i++;
               end
               if (tr_n < 8) begin
                  lg_addr[tr_n] = phy_addr; lg_we[tr_n] = phy_we;
                  lg_wd[tr_n] = phy_wdata; lg_idle[tr_n] = idle;
               end
               tr_n++;
            end
         end else if (busy) begin
            idle++;
         end
      end
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // launches one check; returns the edge count (start edge = 0) after which done was seen
   task automatic run(input logic [31:0] d1_init, input logic [31:0] d1_chg,
                      input int chg_t, input int poke_t, output int t_done);
      int t;
      @(negedge clk);
      run_id++;
      dbg1  = d1_init;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      t = 0;
      forever begin
         @(posedge clk);
         t++;
         @(negedge clk);
         start = 1'b0;
         if (done) break;
         if (t == chg_t)  dbg1  = d1_chg;
         if (t == poke_t) start = 1'b1;
         if (t > 3000) break;
      end
      t_done = t;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int td;
      int recov;
      do_reset();
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 link_up", link_up, 0);
      check("R1 fault", fault, 0);
      check("R1 seen", seen, 0);
      check("R1 count", cnt, 0);
      check("R1 req", phy_req, 0);

      // R3/R4: trained at re-sample j = 0..RTY
      for (int j = 0; j <= RTY; j++) begin
         lat = 1 + (j % 3);
         if (j == 0) run(UP | 32'h0F0F_000F, UP, 0, -1, td);
         else        run(UP | TRN | 32'h0000_0F00, UP | 32'h0F00, 1 + (j - 1) * (W + 1), -1, td);
         check(j == 0 ? "R3 latency" : "R4 latency", td, 1 + j * (W + 1));
         check("R3 link_up", link_up, 1);
         check("R3 no access", tr_n, 0);
         repeat (2) @(negedge clk);
         check("R3 done pulse", done, 0);
         check("R3 result held", link_up, 1);
      end

      // R4: never settles -> stuck check after the last retry
      dbg0 = 32'h0; stat_val = 16'h0000; lat = 2;
      run(UP | TRN, UP | TRN, 0, -1, td);
      check("R4 exhausted latency", td, 1 + RTY * (W + 1) + 2);
      check("R4 exhausted link_up", link_up, 0);
      check("R4 exhausted reads", tr_n, 1);
      check("R4 exhausted addr", lg_addr[0], 16'h100D);

      // R4: link drops during training at re-sample 2
      lat = 3;
      run(UP | TRN, 32'h0, 1 + 1 * (W + 1), -1, td);
      check("R4 drop latency", td, 1 + 2 * (W + 1) + 3);
      check("R4 drop link_up", link_up, 0);

      // R2: start poked while busy is ignored
      lat = 1;
      run(UP | TRN, UP, 1 + 2 * (W + 1), 3, td);
      check("R2 poke latency", td, 1 + 3 * (W + 1));
      begin
         int extra = 0;
         for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         check("R2 no second check", extra, 0);
      end

      // R6/R7: sweep of the state code with link down and receive not valid
      v1 = 16'h1234; v2 = 16'hFFFF; stat_val = 16'hFFFE;
      for (int code = 0; code < 64; code++) begin
         lat  = 1 + (code % 3);
         dbg0 = 32'hA5A5_A5C0 | 32'(code);
         run(32'h0, 32'h0, 0, -1, td);
         check("R6 link_up", link_up, 0);
         if (code != 13) begin
            check("R6 single read", tr_n, 1);
            check("R8 count unchanged", cnt, (code > 13) ? 1 : 0);
            check("R8 seen", seen, (code > 13) ? 1 : 0);
         end else begin
            check("R7 access count", tr_n, 5);
            check("R7 latency", td, 1 + 5 * lat + H);
            check("R7 a1 addr", lg_addr[1], 16'h1005);
            check("R7 a1 read", lg_we[1], 0);
            check("R7 a2 write", lg_we[2], 1);
            check("R7 set value", lg_wd[2], 16'h123C);
            check("R7 hold gap", lg_idle[3], H);
            check("R7 a3 read", lg_we[3], 0);
            check("R7 a3 addr", lg_addr[3], 16'h1005);
            check("R7 clear value", lg_wd[4], 16'hFFD7);
            check("R7 a4 addr", lg_addr[4], 16'h1005);
            check("R8 count one", cnt, 1);
            check("R8 seen set", seen, 1);
         end
      end

      // R5: receive valid blocks recovery even at the lock code
      dbg0 = 32'h0000_000D; stat_val = 16'h0001; lat = 2;
      run(32'h0, 32'h0, 0, -1, td);
      check("R5 single read", tr_n, 1);
      check("R5 count", cnt, 1);

      // R7/R8: further recoveries, other values, saturation at 3
      stat_val = 16'h0000; v1 = 16'h0000; v2 = 16'h0028;
      recov = 1;
      for (int k = 0; k < 4; k++) begin
         lat = 1 + k % 2;
         run(32'h0, 32'h0, 0, -1, td);
         recov++;
         check("R7 set zero base", lg_wd[2], 16'h0028);
         check("R7 clear base", lg_wd[4], 16'h0000);
         check("R8 saturating count", cnt, (recov > 3) ? 3 : recov);
      end

      // R9: error at each access of a recovery
      for (int k = 0; k < 5; k++) begin
         do_reset();
         dbg0 = 32'h0D; stat_val = 16'h0; err_at = k; lat = 1 + k % 3;
         run(32'h0, 32'h0, 0, -1, td);
         check("R9 access count", tr_n, k + 1);
         check("R9 fault", fault, 1);
         check("R9 link_up", link_up, 0);
         check("R9 count", cnt, 0);
         begin
            int reqs = 0;
            for (int m = 0; m < 12; m++) begin
               @(negedge clk);
               if (phy_req) reqs++;
            end
            check("R9 no further access", reqs, 0);
         end
      end
      err_at = -1;
      run(UP, UP, 0, -1, td);
      check("R9 fault sticky", fault, 1);
      check("R3 after fault", link_up, 1);

      check("R10 request stable", stab_err, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule